// File: doc/BRIEF.md
# Word-Wide Static Memory Window Decoder for a 68000-Style Bus

This block lets a 16-bit static memory sit directly on a 68000-style asynchronous bus and respond only inside the 2 MB byte range 0x200000 to 0x3FFFFF. It looks at the top three address lines and the address strobe to form an active-low decode. It inverts that decode into an active-high chip select, which an enable input can block.

Word address bits A20..A1 go straight to the memory address bus. The two data strobes control the two byte lanes independently: the upper strobe controls D15..D8 and the lower strobe controls D7..D0. Output enable is treated as always on, so the read/write line alone sets the direction.

A synthesizable two-lane memory model is included. Its depth is a parameter, so small builds can be used for simulation. Address bits above the chosen depth are ignored inside the window.

Top module: `sram_window_top`

## Requirements
- R1: `ram_cs` is high exactly when `exp_en` is 1, `bus_as_n` is 0 and `bus_addr[23:21]` equals 3'b001. A write presented outside the window changes no stored byte.
- R2: `ram_addr` always equals `bus_addr[20:1]`, giving 1M 16-bit words across the window.
- R3: On a rising clock edge, a lane is written only when `ram_cs` is 1, `bus_rw` is 0 and that lane's strobe is 0. The upper strobe `bus_uds_n` owns lane 1 (data bits 15..8) and the lower strobe `bus_lds_n` owns lane 0 (bits 7..0). An unstrobed lane keeps its byte.
- R4: On a read, a lane is served only when `ram_cs` is 1, `bus_rw` is 1 and that lane's strobe is 0. A served lane drives its stored byte on `rd_data` and sets its bit in `rd_valid` (bit 1 for the upper lane, bit 0 for the lower lane). Every other lane drives 8'h00 with its valid bit at 0, and this includes all lanes outside the window.
- R5: While `exp_en` is 0, `ram_cs` stays low and no lane is written.
- R6: Inside the window, word address bits at and above `DEPTH_LOG2` are ignored, so words that differ only in those bits alias.
- R7: While `rst` is high no lane is written, and `rd_valid` is 0 whenever the bus is idle.
- R8: Storing 16'hFFFF and 16'h0000 in alternating consecutive words, and then the complement of that pattern, reads back unchanged.
- R9: Byte addresses 0x1FFFFE and 0x400000 do not select the block. Addresses 0x200000 and 0x3FFFFE do select it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that commits writes |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| exp_en | input | 1 | Expansion enable; 0 blocks the select |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper data strobe, active low (lane 1) |
| bus_lds_n | input | 1 | Lower data strobe, active low (lane 0) |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 23 | Byte address bits 23..1 |
| bus_wdata | input | 16 | Write data |
| ram_cs | output | 1 | Active-high memory chip select |
| ram_addr | output | 20 | Memory word address (bus A20..A1) |
| rd_data | output | 16 | Read data, unserved lanes zero |
| rd_valid | output | 2 | Per-lane read valid, bit 1 = upper |

## Verification
The bench builds the block with `DEPTH_LOG2` set to 8, which gives a 256-word array. This brings aliasing into reach: a write at byte 0x200200 must show up at 0x200000. It also keeps memory elaboration small. All decode boundaries are exercised at full 24-bit width, because the decoder does not depend on depth.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;

    localparam int BUS_AW      = 24;
    localparam int MEM_AW      = 20;
    localparam int LANES       = 2;
    localparam int LANE_W      = 8;
    localparam logic [2:0] WINDOW_TAG = 3'b001;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } lane_ctl_t;

    function automatic logic tag_hit(input logic [2:0] hi);
        return hi == WINDOW_TAG;
    endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode
    import sram_window_pkg::*;
(
    input  logic [2:0] addr_hi,
    input  logic       as_n,
    input  logic       enable,
    output logic       dec_n,
    output logic       cs
);
    always_comb begin
        dec_n = !(tag_hit(addr_hi) && !as_n);
        cs    = enable && !dec_n;
    end
endmodule

// File: rtl/byte_lane.sv
module byte_lane
    import sram_window_pkg::*;
#(
    parameter int DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic                  strobe_n,
    input  logic                  rw,
    input  logic [DEPTH_LOG2-1:0] idx,
    input  logic [LANE_W-1:0]     wdata,
    output logic [LANE_W-1:0]     rdata,
    output logic                  valid,
    output logic                  we
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [LANE_W-1:0] store [DEPTH];
    lane_ctl_t ctl;

    always_comb begin
        ctl.sel = sel && !strobe_n;
        ctl.wr  = ctl.sel && !rw && !rst;
        ctl.rd  = ctl.sel && rw;
        we      = ctl.wr;
        valid   = ctl.rd;
        rdata   = ctl.rd ? store[idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (ctl.wr) store[idx] <= wdata;
    end
endmodule

// File: rtl/sram_window_top.sv
module sram_window_top
    import sram_window_pkg::*;
#(
    parameter int DEPTH_LOG2 = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exp_en,
    input  logic          bus_as_n,
    input  logic          bus_uds_n,
    input  logic          bus_lds_n,
    input  logic          bus_rw,
    input  logic [23:1]   bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic          ram_cs,
    output logic [19:0]   ram_addr,
    output logic [15:0]   rd_data,
    output logic [1:0]    rd_valid
);
    logic                  dec_n;
    logic [LANES-1:0]      lane_we;
    logic [LANES-1:0]      lane_strobe_n;
    logic [DEPTH_LOG2-1:0] word_idx;

    win_decode u_dec (
        .addr_hi (bus_addr[23:21]),
        .as_n    (bus_as_n),
        .enable  (exp_en),
        .dec_n   (dec_n),
        .cs      (ram_cs)
    );

    assign ram_addr      = bus_addr[MEM_AW:1];
    assign word_idx      = ram_addr[DEPTH_LOG2-1:0];
    assign lane_strobe_n = {bus_uds_n, bus_lds_n};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_lane #(.DEPTH_LOG2(DEPTH_LOG2)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sel      (ram_cs),
            .strobe_n (lane_strobe_n[g]),
            .rw       (bus_rw),
            .idx      (word_idx),
            .wdata    (bus_wdata[g*LANE_W +: LANE_W]),
            .rdata    (rd_data[g*LANE_W +: LANE_W]),
            .valid    (rd_valid[g]),
            .we       (lane_we[g])
        );
    end
endmodule

// File: rtl/sram_window_chk.sv
module sram_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        exp_en,
    input logic        bus_as_n,
    input logic        bus_uds_n,
    input logic        bus_lds_n,
    input logic        bus_rw,
    input logic        ram_cs,
    input logic [15:0] rd_data,
    input logic [1:0]  rd_valid,
    input logic [1:0]  lane_we
);
    // R1
    cs_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> !bus_as_n) else $error("cs without address strobe");

    // R5
    cs_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !exp_en |-> (!ram_cs && lane_we == 2'b00)) else $error("select while disabled");

    // R3
    upper_write_chk: assert property (@(posedge clk) disable iff (rst)
        lane_we[1] |-> (ram_cs && !bus_rw && !bus_uds_n)) else $error("bad upper write");

    // R3
    lower_write_chk: assert property (@(posedge clk) disable iff (rst)
        lane_we[0] |-> (ram_cs && !bus_rw && !bus_lds_n)) else $error("bad lower write");

    // R4
    upper_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid[1] |-> rd_data[15:8] == 8'h00) else $error("upper lane driven");

    // R4
    lower_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid[0] |-> rd_data[7:0] == 8'h00) else $error("lower lane driven");

    // R7
    always @(posedge clk) begin
        if (rst) begin
            reset_write_chk: assert (lane_we == 2'b00) else $error("write during reset");
        end
    end
endmodule

bind sram_window_top sram_window_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .exp_en    (exp_en),
    .bus_as_n  (bus_as_n),
    .bus_uds_n (bus_uds_n),
    .bus_lds_n (bus_lds_n),
    .bus_rw    (bus_rw),
    .ram_cs    (ram_cs),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .lane_we   (lane_we)
);

// File: tb/sram_window_top_test.sv
module sram_window_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exp_en = 1'b0;
    logic        bus_as_n = 1'b1;
    logic        bus_uds_n = 1'b1;
    logic        bus_lds_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [23:1] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        ram_cs;
    logic [19:0] ram_addr;
    logic [15:0] rd_data;
    logic [1:0]  rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    sram_window_top #(.DEPTH_LOG2(8)) uut (
        .clk(clk), .rst(rst), .exp_en(exp_en), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ram_cs(ram_cs),
        .ram_addr(ram_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_rw = 1'b1;
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [15:0] d, input logic [1:0] lanes);
        @(negedge clk);
        bus_addr = a[23:1]; bus_wdata = d; bus_rw = 1'b0; bus_as_n = 1'b0;
        bus_uds_n = !lanes[1]; bus_lds_n = !lanes[0];
        @(posedge clk);
        idle();
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [1:0] lanes,
                            output logic [15:0] d, output logic [1:0] v);
        @(negedge clk);
        bus_addr = a[23:1]; bus_rw = 1'b1; bus_as_n = 1'b0;
        bus_uds_n = !lanes[1]; bus_lds_n = !lanes[0];
        #1;
        d = rd_data; v = rd_valid;
        idle();
    endtask

    task automatic sel_at(input logic [23:0] a, output logic cs, output logic [19:0] ma);
        @(negedge clk);
        bus_addr = a[23:1]; bus_rw = 1'b1; bus_as_n = 1'b0;
        bus_uds_n = 1'b1; bus_lds_n = 1'b1;
        #1;
        cs = ram_cs; ma = ram_addr;
        idle();
    endtask

    task automatic t_reset();
        logic [15:0] d; logic [1:0] v;
        check("R7 idle cs in reset", {31'd0, ram_cs}, 32'd0);
        check("R7 idle valid in reset", {30'd0, rd_valid}, 32'd0);
        @(negedge clk); rst = 1'b0; exp_en = 1'b1;
        bus_write(24'h200010, 16'h1234, 2'b11);
        @(negedge clk); rst = 1'b1;
        bus_write(24'h200010, 16'hDEAD, 2'b11);
        @(negedge clk); rst = 1'b0;
        bus_read(24'h200010, 2'b11, d, v);
        check("R7 write blocked by reset", {16'd0, d}, 32'h1234);
    endtask

    task automatic t_decode();
        logic cs; logic [19:0] ma;
        sel_at(24'h200000, cs, ma);
        check("R9 0x200000 selects", {31'd0, cs}, 32'd1);
        sel_at(24'h3FFFFE, cs, ma);
        check("R9 0x3FFFFE selects", {31'd0, cs}, 32'd1);
        sel_at(24'h1FFFFE, cs, ma);
        check("R9 0x1FFFFE not selected", {31'd0, cs}, 32'd0);
        sel_at(24'h400000, cs, ma);
        check("R9 0x400000 not selected", {31'd0, cs}, 32'd0);
        sel_at(24'h2ABCDE, cs, ma);
        check("R2 word address", {12'd0, ma}, {12'd0, 20'((24'h2ABCDE >> 1) & 24'hFFFFF)});
        @(negedge clk); bus_addr = 23'(24'h200000 >> 1); bus_as_n = 1'b1; #1;
        check("R1 no select without strobe", {31'd0, ram_cs}, 32'd0);
    endtask

    task automatic t_lanes();
        logic [15:0] d; logic [1:0] v;
        bus_write(24'h200020, 16'hA5C3, 2'b11);
        bus_write(24'h200020, 16'h11EE, 2'b10);
        bus_read(24'h200020, 2'b11, d, v);
        check("R3 upper lane only", {14'd0, v, d}, {14'd0, 2'b11, 16'h11C3});
        bus_write(24'h200020, 16'hEE22, 2'b01);
        bus_read(24'h200020, 2'b11, d, v);
        check("R3 lower lane only", {16'd0, d}, 32'h1122);
        bus_read(24'h200020, 2'b10, d, v);
        check("R4 upper read only", {14'd0, v, d}, {14'd0, 2'b10, 16'h1100});
        bus_read(24'h200020, 2'b01, d, v);
        check("R4 lower read only", {14'd0, v, d}, {14'd0, 2'b01, 16'h0022});
        bus_read(24'h000020, 2'b11, d, v);
        check("R4 outside read undriven", {14'd0, v, d}, 32'd0);
    endtask

    task automatic t_enable_outside();
        logic [15:0] d; logic [1:0] v; logic cs; logic [19:0] ma;
        @(negedge clk); exp_en = 1'b0;
        sel_at(24'h200020, cs, ma);
        check("R5 disabled no select", {31'd0, cs}, 32'd0);
        bus_write(24'h200020, 16'hFFFF, 2'b11);
        @(negedge clk); exp_en = 1'b1;
        bus_read(24'h200020, 2'b11, d, v);
        check("R5 disabled write ignored", {16'd0, d}, 32'h1122);
        bus_write(24'h000020, 16'h9999, 2'b11);
        bus_read(24'h200020, 2'b11, d, v);
        check("R1 outside write ignored", {16'd0, d}, 32'h1122);
    endtask

    task automatic t_alias();
        logic [15:0] d; logic [1:0] v;
        bus_write(24'h200200, 16'h7E81, 2'b11);
        bus_read(24'h200000, 2'b11, d, v);
        check("R6 high word bits alias", {16'd0, d}, 32'h7E81);
    endtask

    task automatic t_pattern();
        logic [15:0] d; logic [1:0] v;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 8; k++)
                bus_write(24'h200100 + 24'(2*k), ((k % 2) == pass) ? 16'hFFFF : 16'h0000, 2'b11);
            for (int k = 0; k < 8; k++) begin
                bus_read(24'h200100 + 24'(2*k), 2'b11, d, v);
                check("R8 alternating pattern", {16'd0, d},
                      {16'd0, ((k % 2) == pass) ? 16'hFFFF : 16'h0000});
            end
        end
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    errors++; checks++;
                    $display("FAIL watchdog actual=running expected=finished");
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none
        repeat (2) @(negedge clk);
        t_reset();
        t_decode();
        t_lanes();
        t_enable_outside();
        t_alias();
        t_pattern();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule